// File: doc/BRIEF.md
# Pulse-Stepped Channel Volume Controller

This block keeps one channel volume setting and lets a board adjust it with nothing but two strap-style pins, for systems where the host control bus is switched off. A rising edge on the "down" pin lowers the volume by half a decibel. A rising edge on the "up" pin raises it by half a decibel. When both pins rise together, the setting returns to unity gain.

Both pins are taken from outside the clock domain. Each one passes through a synchroniser chain and an edge detector. A short coincidence window then decides whether two edges count as one joint event or as two separate steps. The result is a signed code in half-dB units, together with a flag that tells the external-amplifier path to apply that code. The line-out path never uses this code.

Top module: `pulse_vol_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `amp_vol_code` is -120 (9-bit two's complement, half-dB units, so -60 dB) and `vol_upd` is 0. `amp_vol_en` is 0 during reset.
- R2: A rising edge on `vol_up_pin` with no edge on `vol_dn_pin` inside the window raises the code by exactly 1.
- R3: A rising edge on `vol_dn_pin` with no edge on `vol_up_pin` inside the window lowers the code by exactly 1.
- R4: When both pins rise in the same cycle, the code becomes 0 (0 dB) and no step is applied.
- R5: When the second pin rises up to 3 clock cycles after the first, the pair is treated as one joint event. The code becomes 0 and no step is applied, whichever pin came first.
- R6: When the second pin rises 4 or more cycles after the first, each edge produces its own single step, in arrival order.
- R7: An up step while the code is 0 leaves the code at 0.
- R8: A down step while the code is -200 (-100 dB) leaves the code at -200.
- R9: `vol_upd` is high for exactly one cycle, in the same cycle that a new code value first appears. It stays low when an event leaves the code unchanged.
- R10: While `ctl_bus_off` is 0, pin edges are ignored, the code is held and `amp_vol_en` is 0. While `ctl_bus_off` is 1, `amp_vol_en` is 1.
- R11: Only a rising edge counts. A pin held high for many cycles gives one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_bus_off | input | 1 | Strap: 1 enables pin-driven volume control |
| vol_dn_pin | input | 1 | Asynchronous pin; a rising edge steps the volume down |
| vol_up_pin | input | 1 | Asynchronous pin; a rising edge steps the volume up |
| amp_vol_code | output | 9 | Signed volume code in half-dB units for the amplifier path |
| amp_vol_en | output | 1 | Amplifier path applies `amp_vol_code` |
| vol_upd | output | 1 | One-cycle strobe on each code change |

## Verification
The bench places the second pin's edge exactly 3 cycles and exactly 4 cycles after the first. A window that is one cycle off would turn a joint reset into two steps, or two steps into a reset. It drives a joint event when the code is already 0. A design that also applied the first pin's step would land on -1, or would raise a strobe with no change. It also pushes past both limits: a design without the clamp would wrap or go past -200 or 0. Finally, it holds a pin high for a long time and pulses the pins while the strap is low, which catches level counting and a missing enable.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_UP    = 2'd1,
        EV_DN    = 2'd2,
        EV_UNITY = 2'd3
    } vol_ev_e;

    typedef enum logic [1:0] {
        CW_IDLE = 2'd0,
        CW_UP   = 2'd1,
        CW_DN   = 2'd2
    } cw_state_e;
endpackage

// File: rtl/pvc_edge_sync.sv
module pvc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sh   = {st_q.sh[STAGES-2:0], pin};
        st_d.prev = st_q.sh[STAGES-1];
        rise      = st_q.sh[STAGES-1] & ~st_q.prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R11: a held level gives a single detected edge
    assert_single_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/pvc_coinc.sv
module pvc_coinc
    import pvc_pkg::*;
#(
    parameter int WIN = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    en,
    input  logic    up_rise,
    input  logic    dn_rise,
    output vol_ev_e ev
);
    localparam int CNT_W = $clog2(WIN) + 1;

    typedef struct packed {
        cw_state_e        st;
        logic [CNT_W-1:0] cnt;
        vol_ev_e          ev;
    } cw_t;

    cw_t cw_d, cw_q;

    always_comb begin
        cw_d    = cw_q;
        cw_d.ev = EV_NONE;
        if (!en) begin
            cw_d.st  = CW_IDLE;
            cw_d.cnt = '0;
        end else begin
            case (cw_q.st)
                CW_IDLE: begin
                    if (up_rise && dn_rise) begin
                        cw_d.ev = EV_UNITY;
                    end else if (up_rise) begin
                        cw_d.st  = CW_UP;
                        cw_d.cnt = CNT_W'(1);
                    end else if (dn_rise) begin
                        cw_d.st  = CW_DN;
                        cw_d.cnt = CNT_W'(1);
                    end
                end
                CW_UP, CW_DN: begin
                    if ((cw_q.st == CW_UP && dn_rise) || (cw_q.st == CW_DN && up_rise)) begin
                        cw_d.ev  = EV_UNITY;
                        cw_d.st  = CW_IDLE;
                        cw_d.cnt = '0;
                    end else if (cw_q.cnt == CNT_W'(WIN - 1)) begin
                        cw_d.ev  = (cw_q.st == CW_UP) ? EV_UP : EV_DN;
                        cw_d.st  = CW_IDLE;
                        cw_d.cnt = '0;
                    end else begin
                        cw_d.cnt = cw_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    cw_d.st  = CW_IDLE;
                    cw_d.cnt = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cw_q <= '{st: CW_IDLE, cnt: '0, ev: EV_NONE};
        else        cw_q <= cw_d;
    end

    assign ev = cw_q.ev;

    // R4: edges that land together produce the joint event
    assert_joint_same_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cw_q.st == CW_IDLE && up_rise && dn_rise) |=> ev == EV_UNITY);

    // R10: no event leaves while the strap is low
    assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> ev == EV_NONE);

    // R5: an opposite edge inside an open window never yields a step
    assert_window_joint_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cw_q.st == CW_UP && dn_rise) |=> ev == EV_UNITY);
endmodule

// File: rtl/pvc_vol_reg.sv
module pvc_vol_reg
    import pvc_pkg::*;
#(
    parameter int CODE_W    = 9,
    parameter int CODE_MIN  = -200,
    parameter int CODE_MAX  = 0,
    parameter int CODE_INIT = -120,
    parameter int CODE_UNIT = 0
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en,
    input  vol_ev_e                  ev,
    output logic signed [CODE_W-1:0] code,
    output logic                     upd,
    output logic                     amp_en
);
    localparam logic signed [CODE_W-1:0] MIN_C  = CODE_W'(CODE_MIN);
    localparam logic signed [CODE_W-1:0] MAX_C  = CODE_W'(CODE_MAX);
    localparam logic signed [CODE_W-1:0] INIT_C = CODE_W'(CODE_INIT);
    localparam logic signed [CODE_W-1:0] UNIT_C = CODE_W'(CODE_UNIT);

    typedef struct packed {
        logic signed [CODE_W-1:0] code;
        logic                     upd;
        logic                     amp_en;
    } vr_t;

    vr_t vr_d, vr_q;
    logic signed [CODE_W-1:0] nxt;

    always_comb begin
        nxt = vr_q.code;
        case (ev)
            EV_UP:    if (vr_q.code < MAX_C) nxt = vr_q.code + CODE_W'(1);
            EV_DN:    if (vr_q.code > MIN_C) nxt = vr_q.code - CODE_W'(1);
            EV_UNITY: nxt = UNIT_C;
            default:  nxt = vr_q.code;
        endcase
        vr_d.code   = nxt;
        vr_d.upd    = (nxt != vr_q.code);
        vr_d.amp_en = en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vr_q <= '{code: INIT_C, upd: 1'b0, amp_en: 1'b0};
        else        vr_q <= vr_d;
    end

    assign code   = vr_q.code;
    assign upd    = vr_q.upd;
    assign amp_en = vr_q.amp_en;

    // R7, R8: code stays between the limits
    assert_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        code >= MIN_C && code <= MAX_C);

    // R9: strobe marks exactly the cycles where the code moved
    assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (upd == (code != $past(code))));

    // R4: joint event lands on unity
    assert_unity_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ev == EV_UNITY |=> code == UNIT_C);

    // R2: an up event below the ceiling moves by one
    assert_up_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_UP && code < MAX_C) |=> code == $past(code) + CODE_W'(1));

    // R3: a down event above the floor moves by one
    assert_dn_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_DN && code > MIN_C) |=> code == $past(code) - CODE_W'(1));
endmodule

// File: rtl/pulse_vol_ctrl.sv
module pulse_vol_ctrl
    import pvc_pkg::*;
#(
    parameter int CODE_W      = 9,
    parameter int CODE_MIN    = -200,
    parameter int CODE_MAX    = 0,
    parameter int CODE_INIT   = -120,
    parameter int WIN         = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_bus_off,
    input  logic                     vol_dn_pin,
    input  logic                     vol_up_pin,
    output logic signed [CODE_W-1:0] amp_vol_code,
    output logic                     amp_vol_en,
    output logic                     vol_upd
);
    localparam int N_PINS  = 2;
    localparam int IDX_DN  = 0;
    localparam int IDX_UP  = 1;

    logic [N_PINS-1:0] pin_v;
    logic [N_PINS-1:0] rise_v;
    vol_ev_e           ev;

    assign pin_v[IDX_DN] = vol_dn_pin;
    assign pin_v[IDX_UP] = vol_up_pin;

    for (genvar i = 0; i < N_PINS; i++) begin : g_sync
        pvc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (pin_v[i]),
            .rise (rise_v[i])
        );
    end

    pvc_coinc #(.WIN(WIN)) u_coinc (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ctl_bus_off),
        .up_rise(rise_v[IDX_UP]),
        .dn_rise(rise_v[IDX_DN]),
        .ev     (ev)
    );

    pvc_vol_reg #(
        .CODE_W   (CODE_W),
        .CODE_MIN (CODE_MIN),
        .CODE_MAX (CODE_MAX),
        .CODE_INIT(CODE_INIT),
        .CODE_UNIT(0)
    ) u_vol (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (ctl_bus_off),
        .ev    (ev),
        .code  (amp_vol_code),
        .upd   (vol_upd),
        .amp_en(amp_vol_en)
    );
endmodule

// File: tb/pulse_vol_ctrl_tb.sv
module pulse_vol_ctrl_tb_top;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic              up1;
        logic              two;
        logic [3:0]        lag;
        logic [4:0]        width;
        logic signed [8:0] code;
        logic [1:0]        nstb;
    } vec_t;

    // R2 R3 R4 R5 R6 R7 R9 R11 vectors, starting from code -120
    localparam vec_t VECS [11] = '{
        '{1'b1, 1'b0, 4'd0, 5'd2,  -9'sd119, 2'd1},
        '{1'b0, 1'b0, 4'd0, 5'd2,  -9'sd120, 2'd1},
        '{1'b0, 1'b1, 4'd0, 5'd2,   9'sd0,   2'd1},
        '{1'b1, 1'b0, 4'd0, 5'd2,   9'sd0,   2'd0},
        '{1'b0, 1'b0, 4'd0, 5'd2,  -9'sd1,   2'd1},
        '{1'b1, 1'b1, 4'd3, 5'd2,   9'sd0,   2'd1},
        '{1'b0, 1'b1, 4'd3, 5'd2,   9'sd0,   2'd0},
        '{1'b0, 1'b0, 4'd0, 5'd2,  -9'sd1,   2'd1},
        '{1'b0, 1'b1, 4'd4, 5'd2,  -9'sd1,   2'd2},
        '{1'b1, 1'b0, 4'd0, 5'd20,  9'sd0,   2'd1},
        '{1'b1, 1'b1, 4'd0, 5'd2,   9'sd0,   2'd0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ctl_bus_off = 1'b1;
    logic              vol_dn_pin = 1'b0;
    logic              vol_up_pin = 1'b0;
    logic signed [8:0] amp_vol_code;
    logic              amp_vol_en;
    logic              vol_upd;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    pulse_vol_ctrl dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_bus_off (ctl_bus_off),
        .vol_dn_pin  (vol_dn_pin),
        .vol_up_pin  (vol_up_pin),
        .amp_vol_code(amp_vol_code),
        .amp_vol_en  (amp_vol_en),
        .vol_upd     (vol_upd)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic send(input logic up1, input logic two, input int lag,
                        input int width, output int nstb);
        nstb = 0;
        for (int t = 0; t < lag + width + 16; t++) begin
            logic a, b;
            a = (t < width);
            b = two && (t >= lag) && (t < lag + width);
            vol_up_pin = up1 ? a : b;
            vol_dn_pin = up1 ? b : a;
            @(negedge clk);
            if (vol_upd) nstb++;
        end
        vol_up_pin = 1'b0;
        vol_dn_pin = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog got 0 expected 1");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int ns;
        repeat (3) @(negedge clk);
        check("R1 reset code", int'(amp_vol_code), -120);
        check("R1 reset strobe", int'(vol_upd), 0);
        check("R1 reset enable", int'(amp_vol_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 code after release", int'(amp_vol_code), -120);
        check("R10 enable follows strap", int'(amp_vol_en), 1);

        for (int i = 0; i < 11; i++) begin
            send(VECS[i].up1, VECS[i].two, int'(VECS[i].lag), int'(VECS[i].width), ns);
            check($sformatf("R2/R3/R4/R5/R6/R7/R11 vec%0d code", i),
                  int'(amp_vol_code), int'(VECS[i].code));
            check($sformatf("R9 vec%0d strobes", i), ns, int'(VECS[i].nstb));
        end

        // R8: walk down to the floor and push once more
        for (int k = 0; k < 200; k++) send(1'b0, 1'b0, 0, 2, ns);
        check("R8 floor reached", int'(amp_vol_code), -200);
        send(1'b0, 1'b0, 0, 2, ns);
        check("R8 floor held", int'(amp_vol_code), -200);
        check("R8 R9 no strobe at floor", ns, 0);

        // R10: strap low ignores pins
        ctl_bus_off = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R10 enable low", int'(amp_vol_en), 0);
        send(1'b1, 1'b0, 0, 2, ns);
        check("R10 up ignored", int'(amp_vol_code), -200);
        send(1'b0, 1'b1, 0, 2, ns);
        check("R10 joint ignored", int'(amp_vol_code), -200);
        check("R10 no strobe", ns, 0);
        ctl_bus_off = 1'b1;
        @(negedge clk);
        @(negedge clk);
        send(1'b1, 1'b0, 0, 2, ns);
        check("R2 step after re-enable", int'(amp_vol_code), -199);
        check("R10 enable back", int'(amp_vol_en), 1);

        // R1: reset mid-run restores the power-up code
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again code", int'(amp_vol_code), -120);
        check("R1 reset again strobe", int'(vol_upd), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule